// File: doc/BRIEF.md
# Sliding-Window Reuse Buffer

This block sits between a wide sequential memory stream and an unrolled three-tap datapath. The memory side delivers 128-bit beats, each holding four consecutive 32-bit array elements. The datapath side expects, every cycle it can take data, a group of four consecutive 3-element windows. Window k is made of elements k, k+1 and k+2. Consecutive windows therefore overlap by two elements, and consecutive groups share elements across a beat boundary. The block keeps the most recent beat in local storage and joins it with the leading elements of the next beat. Every element is then fetched from memory exactly once, while the datapath receives six elements' worth of operands per cycle from four elements of memory traffic.

No group is released until it is complete. The first beat on its own could only serve two windows, so the datapath never sees a short first group and needs no special start-up control. The total window count is a parameter. When it is not a multiple of four, the last group carries a per-window valid mask. If the last group needs no element beyond those already stored, it is released without fetching another beat. A beat counter shows how many memory reads have been made. A sticky completion flag rises once the final group has been taken downstream.

Top module: `sw_reuse_buffer`

## Requirements
- R1: Lane l of an input beat sits in bits [32*l+31 : 32*l] and holds the element whose index is 4*b+l, where b is the beat's position in the stream counted from 0. Lane 0 carries the lowest index.
- R2: In output group g, window j (j = 0..3) occupies slots 3*j .. 3*j+2, and slot 3*j+s sits in `out_win` bits [32*(3*j+s)+31 : 32*(3*j+s)]. Slot s of that window holds element 4*g+j+s.
- R3: Over a stream of NUM_WIN windows, exactly ceil((NUM_WIN+2)/4) beats are accepted. `rd_count` increases by one on each accepted beat, and `in_ready` stays low once the last beat has been taken.
- R4: `out_valid` stays low until two beats have been accepted. The first group presented holds windows 0 to 3, and `rd_count` reads 2 while it is first shown.
- R5: When input is always valid and `out_ready` is always high, groups come out in consecutive cycles, one per cycle, from the first group to the last, with no idle cycle between them.
- R6: While `out_valid` is high and `out_ready` is low, `out_win` and `out_mask` hold their values and `in_ready` is low. Every group is delivered exactly once, in order.
- R7: Bit j of `out_mask` is 1 exactly when window 4*g+j is below NUM_WIN. When NUM_WIN mod 4 is 1 or 2, the final group is presented after the last beat without any further input. Bit 0 is always 1 while `out_valid` is high.
- R8: `done` rises in the cycle after the final group is accepted and then stays high. While `done` is high, `out_valid` and `in_ready` are low.
- R9: Synchronous active-high `rst` clears the stored beat, the fill state and all counters, even in the middle of a stream. During reset `out_valid`, `done` and `rd_count` are 0 and `in_ready` is 1. A stream started afterwards begins again at window 0.
- R10: Every group before the final one has `out_mask` equal to 4'b1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Memory beat present |
| in_ready | output | 1 | Block can take a beat this cycle |
| in_data | input | 128 | Four elements, lane 0 lowest index |
| out_valid | output | 1 | A window group is presented |
| out_ready | input | 1 | Datapath takes the group this cycle |
| out_win | output | 384 | Twelve element slots, four windows of three |
| out_mask | output | 4 | Per-window valid bits of the group |
| rd_count | output | CNT_W (5 at default) | Beats read from memory since reset |
| done | output | 1 | Final group has been taken |

## Verification
The assertions assume that the upstream side delivers beats strictly in array order and does not withdraw or alter a beat it has offered. They also assume that the stream length matches NUM_WIN, so `rd_count` can only move on a handshake. The bench drives beats in index order and holds each beat's value until the cycle in which it is accepted. It varies only the timing of `in_valid` and `out_ready`, using regular gap patterns on each side. Data contents come from a fixed function of the element index, so any lost, repeated or stale element shows up as a wrong slot value.

// File: rtl/sw_reuse_pkg.sv
package sw_reuse_pkg;
    localparam int ELEM_W  = 32;
    localparam int LANES   = 4;
    localparam int WIN_LEN = 3;
    localparam int OVERLAP = WIN_LEN - 1;
    localparam int BEAT_W  = ELEM_W * LANES;
    localparam int SLOTS   = LANES * WIN_LEN;

    typedef logic [ELEM_W-1:0] elem_t;
    typedef elem_t [LANES-1:0] beat_t;
    typedef elem_t [SLOTS-1:0] group_t;
    typedef elem_t [OVERLAP-1:0] ahead_t;

    // number of output groups for a window count
    function automatic int groups_for(int n_win);
        return (n_win + LANES - 1) / LANES;
    endfunction

    // number of memory beats needed to cover every element once
    function automatic int beats_for(int n_win);
        return (n_win + OVERLAP + LANES - 1) / LANES;
    endfunction
endpackage

// File: rtl/sw_beat_store.sv
module sw_beat_store
    import sw_reuse_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  beat_t beat_in,
    output beat_t held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (load) begin
            held <= beat_in;
        end
    end
endmodule

// File: rtl/sw_window_build.sv
module sw_window_build
    import sw_reuse_pkg::*;
(
    input  beat_t  held,
    input  ahead_t ahead,
    output group_t slots
);
    for (genvar j = 0; j < LANES; j++) begin : g_win
        for (genvar s = 0; s < WIN_LEN; s++) begin : g_slot
            if (j + s < LANES) begin : g_old
                assign slots[j*WIN_LEN + s] = held[j + s];
            end else begin : g_new
                assign slots[j*WIN_LEN + s] = ahead[j + s - LANES];
            end
        end
    end
endmodule

// File: rtl/sw_flow_ctrl.sv
module sw_flow_ctrl
    import sw_reuse_pkg::*;
#(
    parameter  int NUM_WIN = 100,
    localparam int NB      = beats_for(NUM_WIN),
    localparam int NG      = groups_for(NUM_WIN),
    localparam int CNT_W   = $clog2(NB + 1),
    localparam int GW      = $clog2(NG + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             in_fire,
    output logic             load_grp,
    output logic             use_ahead,
    output logic             out_valid,
    output logic [LANES-1:0] out_mask,
    output logic [CNT_W-1:0] rd_count,
    output logic             done
);
    localparam bit             NEED_FLUSH = (NB == NG);
    localparam logic [CNT_W-1:0] NB_C     = CNT_W'(NB);
    localparam logic [GW-1:0]    LAST_G   = GW'(NG - 1);

    logic [CNT_W-1:0] beats_in;
    logic [GW-1:0]    grp_idx;
    logic [GW-1:0]    grp_taken;
    logic             flushed;
    logic             slot_free;
    logic             out_fire;
    logic             flush_go;

    assign slot_free = !out_valid || out_ready;
    assign out_fire  = out_valid && out_ready;
    assign in_ready  = (beats_in < NB_C) && slot_free;
    assign in_fire   = in_valid && in_ready;
    assign flush_go  = NEED_FLUSH && (beats_in == NB_C) && !flushed && slot_free;
    assign load_grp  = (in_fire && (beats_in != '0)) || flush_go;
    assign use_ahead = !flush_go;
    assign rd_count  = beats_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            beats_in  <= '0;
            grp_idx   <= '0;
            grp_taken <= '0;
            flushed   <= 1'b0;
            out_valid <= 1'b0;
            done      <= 1'b0;
        end else begin
            if (in_fire) begin
                beats_in <= beats_in + 1'b1;
            end
            if (load_grp) begin
                out_valid <= 1'b1;
                grp_idx   <= flush_go ? LAST_G : GW'(beats_in - 1'b1);
                if (flush_go) begin
                    flushed <= 1'b1;
                end
            end else if (out_fire) begin
                out_valid <= 1'b0;
            end
            if (out_fire) begin
                grp_taken <= grp_taken + 1'b1;
                if (grp_taken == LAST_G) begin
                    done <= 1'b1;
                end
            end
        end
    end

    for (genvar j = 0; j < LANES; j++) begin : g_mask
        assign out_mask[j] = (int'(grp_idx) * LANES + j) < NUM_WIN;
    end
endmodule

// File: rtl/sw_reuse_buffer.sv
module sw_reuse_buffer
    import sw_reuse_pkg::*;
#(
    parameter  int NUM_WIN = 100,
    localparam int CNT_W   = $clog2(beats_for(NUM_WIN) + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [BEAT_W-1:0]       in_data,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [SLOTS*ELEM_W-1:0] out_win,
    output logic [LANES-1:0]        out_mask,
    output logic [CNT_W-1:0]        rd_count,
    output logic                    done
);
    beat_t  in_beat;
    beat_t  held;
    ahead_t ahead;
    group_t built;
    group_t grp_q;
    logic   in_fire;
    logic   load_grp;
    logic   use_ahead;

    assign in_beat = in_data;

    sw_flow_ctrl #(.NUM_WIN(NUM_WIN)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .in_fire   (in_fire),
        .load_grp  (load_grp),
        .use_ahead (use_ahead),
        .out_valid (out_valid),
        .out_mask  (out_mask),
        .rd_count  (rd_count),
        .done      (done)
    );

    sw_beat_store u_store (
        .clk     (clk),
        .rst     (rst),
        .load    (in_fire),
        .beat_in (in_beat),
        .held    (held)
    );

    // leading elements of the incoming beat, zero on the closing flush
    always_comb begin
        for (int i = 0; i < OVERLAP; i++) begin
            ahead[i] = use_ahead ? in_beat[i] : '0;
        end
    end

    sw_window_build u_build (
        .held  (held),
        .ahead (ahead),
        .slots (built)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_q <= '0;
        end else if (load_grp) begin
            grp_q <= built;
        end
    end

    assign out_win = grp_q;
endmodule

// File: rtl/sw_reuse_buffer_chk.sv
module sw_reuse_buffer_chk
    import sw_reuse_pkg::*;
#(
    parameter  int NUM_WIN = 100,
    localparam int NB      = beats_for(NUM_WIN),
    localparam int CNT_W   = $clog2(NB + 1)
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic [SLOTS*ELEM_W-1:0] out_win,
    input logic [LANES-1:0]        out_mask,
    input logic [CNT_W-1:0]        rd_count,
    input logic                    done
);
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_win) && $stable(out_mask));

    a_r6_hold_blocks_input: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready);

    a_r3_stop_after_last: assert property (@(posedge clk) disable iff (rst)
        (int'(rd_count) == NB) |-> !in_ready);

    a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> rd_count == $past(rd_count) + CNT_W'($past(in_valid && in_ready)));

    a_r4_holdoff: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> int'(rd_count) >= 2);

    a_r7_mask_lead: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_mask[0]);

    a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !out_valid && !in_ready);
endmodule

bind sw_reuse_buffer sw_reuse_buffer_chk #(.NUM_WIN(NUM_WIN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_win   (out_win),
    .out_mask  (out_mask),
    .rd_count  (rd_count),
    .done      (done)
);

// File: tb/sw_reuse_buffer_bench.sv
module sw_reuse_buffer_bench;
    localparam int NW_A = 100;
    localparam int NW_B = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic         sel = 1'b0;
    logic         drv_valid = 1'b0;
    logic         drv_ready = 1'b0;
    logic [127:0] drv_data = '0;

    logic         in_ready_a, out_valid_a, done_a;
    logic [383:0] win_a;
    logic [3:0]   mask_a;
    logic [4:0]   rd_a;
    logic         in_ready_b, out_valid_b, done_b;
    logic [383:0] win_b;
    logic [3:0]   mask_b;
    logic [1:0]   rd_b;

    sw_reuse_buffer #(.NUM_WIN(NW_A)) u_sw_reuse_buffer (
        .clk(clk), .rst(rst),
        .in_valid(drv_valid && !sel), .in_ready(in_ready_a), .in_data(drv_data),
        .out_valid(out_valid_a), .out_ready(drv_ready && !sel),
        .out_win(win_a), .out_mask(mask_a), .rd_count(rd_a), .done(done_a)
    );

    sw_reuse_buffer #(.NUM_WIN(NW_B)) u_sw_reuse_buffer_short (
        .clk(clk), .rst(rst),
        .in_valid(drv_valid && sel), .in_ready(in_ready_b), .in_data(drv_data),
        .out_valid(out_valid_b), .out_ready(drv_ready && sel),
        .out_win(win_b), .out_mask(mask_b), .rd_count(rd_b), .done(done_b)
    );

    logic         obs_in_ready, obs_valid, obs_done;
    logic [383:0] obs_win;
    logic [3:0]   obs_mask;
    logic [7:0]   obs_rd;
    assign obs_in_ready = sel ? in_ready_b  : in_ready_a;
    assign obs_valid    = sel ? out_valid_b : out_valid_a;
    assign obs_done     = sel ? done_b      : done_a;
    assign obs_win      = sel ? win_b       : win_a;
    assign obs_mask     = sel ? mask_b      : mask_a;
    assign obs_rd       = sel ? 8'(rd_b)    : 8'(rd_a);

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL R5 watchdog actual=hung expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [31:0] elem(int i, int nw);
        if (i < nw + 2) return 32'hA000_0000 ^ (32'(i) * 32'h0000_0101);
        return 32'hDEAD_BEEF;
    endfunction

    // R1: lane l of beat b carries element 4*b+l
    function automatic logic [127:0] beat_val(int b, int nw);
        logic [127:0] v;
        for (int l = 0; l < 4; l++) v[32*l +: 32] = elem(4*b + l, nw);
        return v;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; drv_valid = 1'b0; drv_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_stream(bit use_b, int in_gap, int out_gap, bit full_rate);
        int nw = use_b ? NW_B : NW_A;
        int nb = (nw + 2 + 3) / 4;
        int ng = (nw + 3) / 4;
        int gaps = 0;
        sel = use_b;
        do_reset();
        fork
            begin : producer
                int b = 0;
                int k = 0;
                while (b < nb) begin
                    @(negedge clk);
                    drv_valid = (in_gap == 0) || ((k % in_gap) != 0);
                    drv_data  = beat_val(b, nw);
                    k++;
                    #1;
                    if (drv_valid && obs_in_ready) b++;
                end
                @(negedge clk);
                drv_valid = 1'b0;
            end
            begin : consumer
                int g = 0;
                int k = 0;
                bit started = 1'b0;
                while (g < ng) begin
                    @(negedge clk);
                    drv_ready = (out_gap == 0) || ((k % out_gap) != 0);
                    k++;
                    #1;
                    if (obs_valid) begin
                        if (!started) begin
                            chk(obs_rd == 8'd2, "R4", "beats read at first group", 64'(obs_rd), 64'd2);
                            started = 1'b1;
                        end
                        if (drv_ready) begin
                            bit ok = 1'b1;
                            logic [31:0] fa = '0;
                            logic [31:0] fe = '0;
                            logic [3:0] em = '0;
                            for (int j = 0; j < 4; j++) begin
                                em[j] = (4*g + j) < nw;
                                for (int s = 0; s < 3; s++) begin
                                    if (em[j] && ok && obs_win[32*(3*j+s) +: 32] !== elem(4*g+j+s, nw)) begin
                                        ok = 1'b0;
                                        fa = obs_win[32*(3*j+s) +: 32];
                                        fe = elem(4*g+j+s, nw);
                                    end
                                end
                            end
                            chk(ok, "R2", $sformatf("group %0d slot value", g), 64'(fa), 64'(fe));
                            if (g == ng - 1)
                                chk(obs_mask == em, "R7", "final group mask", 64'(obs_mask), 64'(em));
                            else
                                chk(obs_mask == 4'hF, "R10", $sformatf("group %0d mask", g), 64'(obs_mask), 64'hF);
                            g++;
                        end
                    end else if (started) begin
                        gaps++;
                    end
                end
                @(negedge clk);
                drv_ready = 1'b1;
            end
        join
        if (full_rate)
            chk(gaps == 0, "R5", "idle cycles between groups", 64'(gaps), 64'd0);
        @(negedge clk);
        @(negedge clk);
        #1;
        chk(obs_done == 1'b1, "R8", "done after final group", 64'(obs_done), 64'd1);
        chk(obs_valid == 1'b0, "R8", "no group after done", 64'(obs_valid), 64'd0);
        chk(obs_rd == 8'(nb), "R3", "total beats read", 64'(obs_rd), 64'(nb));
        chk(obs_in_ready == 1'b0, "R3", "input closed after last beat", 64'(obs_in_ready), 64'd0);
        @(negedge clk);
        #1;
        chk(obs_done == 1'b1, "R8", "done stays high", 64'(obs_done), 64'd1);
    endtask

    task automatic t_reset_state();
        sel = 1'b0;
        do_reset();
        rst = 1'b1;
        @(negedge clk);
        #1;
        chk(obs_valid == 1'b0, "R9", "out_valid in reset", 64'(obs_valid), 64'd0);
        chk(obs_done == 1'b0, "R9", "done in reset", 64'(obs_done), 64'd0);
        chk(obs_rd == 8'd0, "R9", "rd_count in reset", 64'(obs_rd), 64'd0);
        chk(obs_in_ready == 1'b1, "R9", "in_ready in reset", 64'(obs_in_ready), 64'd1);
        rst = 1'b0;
    endtask

    task automatic t_midstream_reset();
        sel = 1'b0;
        do_reset();
        for (int b = 0; b < 3; b++) begin
            @(negedge clk);
            drv_ready = 1'b0;
            drv_valid = 1'b1;
            drv_data  = beat_val(b + 5, NW_A);
        end
        #1;
        chk(obs_valid == 1'b1, "R6", "group held", 64'(obs_valid), 64'd1);
        chk(obs_in_ready == 1'b0, "R6", "input blocked while held", 64'(obs_in_ready), 64'd0);
        chk(obs_rd == 8'd2, "R6", "third beat not taken", 64'(obs_rd), 64'd2);
        @(negedge clk);
        rst = 1'b1;
        drv_valid = 1'b0;
        @(negedge clk);
        #1;
        chk(obs_valid == 1'b0 && obs_rd == 8'd0, "R9", "mid-stream reset clears state",
            {32'(obs_valid), 32'(obs_rd)}, 64'd0);
        rst = 1'b0;
        // fresh stream must start again at window 0
        run_stream(1'b0, 0, 0, 1'b1);
    endtask

    initial begin
        t_reset_state();
        run_stream(1'b0, 0, 0, 1'b1);   // R5 full rate
        run_stream(1'b0, 3, 4, 1'b0);   // R6 gaps on both sides
        run_stream(1'b0, 0, 2, 1'b0);   // R6 alternating backpressure
        t_midstream_reset();            // R9
        run_stream(1'b1, 0, 0, 1'b1);   // R7 closing flush, short stream
        run_stream(1'b1, 2, 3, 1'b0);   // R7 with gaps
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule